// File: doc/BRIEF.md
# Proportional Burst-Fire Heater Controller

This block decides, once per mains cycle, whether a resistive heater switched by a thyristor-type device should conduct. It also issues the gate-pulse requests for that device. Every turn-on falls on a mains zero crossing. Conduction is granted only in whole mains cycles: a pulse at the crossing that opens a positive half-cycle, and a second pulse at the crossing that closes it.

Proportional action comes from a slow staircase ramp. A period counter advances once per mains period, and its top bits are added to the setpoint code. The heater is therefore on for a fraction of each ramp period that grows the further the sensed temperature sits below the band. Further inputs shape the decision:

- A reduction request lowers the reference.
- A hysteresis selector widens the comparator's switch-off margin.
- A sensor-open flag stops all gate activity at once.

The comparator state is refreshed only on every DEC_PER-th positive crossing, which keeps the controller immune to noise. The upstream zero-crossing detector must raise `zc_evt` for one clock, PULSE_HALF+1 clocks ahead of the true crossing. The gate pulse of 2·PULSE_HALF clocks is then centred on that crossing.

Top module: `burst_fire_ctrl`

## Requirements
- R1: After synchronous reset `gate_req` is low and `saw_level` is 0, and the first positive crossing after reset performs a decision evaluation.
- R2: An internal CNT_W-bit period counter increments on each positive crossing (`zc_evt`=1 with `zc_pos`=1) and on nothing else, wrapping after 2^CNT_W periods. `saw_level` equals its top SAW_W bits.
- R3: The reference is `setpoint_code + saw_level - (reduce_req ? RED_CODES : 0)`, and from the off state firing is chosen when `sense_code` is strictly below it.
- R4: From the on state, firing continues while `sense_code` is below reference + hysteresis, where hysteresis is HYS_MAX when `hys_max`=1 and HYS_MIN otherwise.
- R5: The comparator state is re-evaluated only on positive crossings numbered 0, DEC_PER, 2·DEC_PER… since reset. On the other crossings the previous decision is reused whatever the inputs.
- R6: The decision is latched at a positive crossing. When it is set, one pulse starts there and one starts at the next negative crossing. A negative crossing never starts a pulse without that latched decision.
- R7: Each pulse keeps `gate_req` high for exactly 2·PULSE_HALF clocks, starting the clock after the `zc_evt` sample.
- R8: While `sensor_open` is high, `gate_req` is low in the same cycle. Any pulse in progress and the latched decision are cancelled, and a positive crossing seen with `sensor_open` high latches no firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| zc_evt | input | 1 | One-cycle zero-crossing marker, PULSE_HALF+1 clocks early |
| zc_pos | input | 1 | With `zc_evt`: 1 = crossing opens a positive half-cycle |
| sense_code | input | SENSE_W | Sensed temperature code (larger = warmer) |
| setpoint_code | input | SENSE_W | Setpoint code |
| reduce_req | input | 1 | Apply the setpoint reduction |
| hys_max | input | 1 | 1 selects the wide hysteresis |
| sensor_open | input | 1 | Sensor-broken flag, blocks firing |
| gate_req | output | 1 | Gate pulse request |
| saw_level | output | SAW_W | Current sawtooth step |

## Verification
The bench builds the block with a 6-bit period counter, a 4-step-wide 16-level staircase, a decision interval of 3 periods, 4-clock pulses, a 20-code reduction and hysteresis widths of 1 and 12 codes. With these values a full ramp lasts only 64 mains periods. All four combinations of reduction and hysteresis can therefore be swept against nine sensor levels spanning the band, covering every ramp step and every counter wrap. Changing the sensor level between evaluations shows the held decision, and a failsafe raised in mid-pulse shows the cancelled pair.

// File: rtl/burst_fire_pkg.sv
package burst_fire_pkg;

  // Control reference: setpoint lifted by the ramp, lowered on request.
  function automatic int ctrl_ref(input int sp, input int saw, input bit red_on,
                                  input int red_amt);
    return sp + saw - (red_on ? red_amt : 0);
  endfunction

  // Comparator with a one-sided switch-off margin.
  function automatic bit cmp_next(input bit on_now, input int sense, input int ref_v,
                                  input int hys);
    if (on_now) return sense < ref_v + hys;
    return sense < ref_v;
  endfunction

endpackage

// File: rtl/bf_period_counter.sv
module bf_period_counter #(
  parameter int CNT_W   = 11,
  parameter int SAW_W   = 4,
  parameter int DEC_PER = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pos_evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SAW_W-1:0] saw,
  output logic             eval_tick
);
  localparam int DEC_W = (DEC_PER > 1) ? $clog2(DEC_PER) : 1;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (pos_evt) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign saw = cnt_q[CNT_W-1 -: SAW_W];

  generate
    if (DEC_PER > 1) begin : g_interval
      logic [DEC_W-1:0] dec_q;
      always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else if (pos_evt)
          dec_q <= (dec_q == DEC_W'(DEC_PER - 1)) ? '0 : dec_q + DEC_W'(1);
      end
      assign eval_tick = pos_evt && (dec_q == '0);
    end else begin : g_every
      assign eval_tick = pos_evt;
    end
  endgenerate
endmodule

// File: rtl/bf_decider.sv
module bf_decider
  import burst_fire_pkg::*;
#(
  parameter int SENSE_W   = 10,
  parameter int SAW_W     = 4,
  parameter int RED_CODES = 80,
  parameter int HYS_MIN   = 2,
  parameter int HYS_MAX   = 80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eval_tick,
  input  logic [SENSE_W-1:0] sense,
  input  logic [SENSE_W-1:0] setpoint,
  input  logic [SAW_W-1:0]   saw,
  input  logic               reduce_req,
  input  logic               hys_max,
  output logic               cmp_q,
  output logic               fire_now
);
  int   ref_v;
  int   hys_v;
  logic cmp_d;

  always_comb begin
    ref_v    = ctrl_ref(int'(setpoint), int'(saw), reduce_req, RED_CODES);
    hys_v    = hys_max ? HYS_MAX : HYS_MIN;
    cmp_d    = cmp_next(cmp_q, int'(sense), ref_v, hys_v);
    fire_now = eval_tick ? cmp_d : cmp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= 1'b0;
    else if (eval_tick) cmp_q <= cmp_d;
  end
endmodule

// File: rtl/bf_pulse_gen.sv
module bf_pulse_gen #(
  parameter int PULSE_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_evt,
  input  logic neg_evt,
  input  logic fire_now,
  input  logic sensor_open,
  output logic fire_hc,
  output logic pulse_start,
  output logic gate_active,
  output logic gate_req
);
  localparam int PW = 2 * PULSE_HALF;
  localparam int TW = $clog2(PW + 1);

  logic [TW-1:0] tmr_q;

  assign pulse_start = !sensor_open && ((pos_evt && fire_now) || (neg_evt && fire_hc));

  always_ff @(posedge clk) begin
    if (rst || sensor_open) begin
      fire_hc <= 1'b0;
      tmr_q   <= '0;
    end else begin
      if (pos_evt)      fire_hc <= fire_now;
      else if (neg_evt) fire_hc <= 1'b0;
      if (pulse_start)      tmr_q <= TW'(PW);
      else if (tmr_q != '0) tmr_q <= tmr_q - TW'(1);
    end
  end

  assign gate_active = (tmr_q != '0);
  assign gate_req    = gate_active && !sensor_open;
endmodule

// File: rtl/burst_fire_ctrl.sv
module burst_fire_ctrl #(
  parameter int SENSE_W    = 10,
  parameter int CNT_W      = 11,
  parameter int SAW_W      = 4,
  parameter int DEC_PER    = 17,
  parameter int PULSE_HALF = 4,
  parameter int RED_CODES  = 80,
  parameter int HYS_MIN    = 2,
  parameter int HYS_MAX    = 80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               zc_evt,
  input  logic               zc_pos,
  input  logic [SENSE_W-1:0] sense_code,
  input  logic [SENSE_W-1:0] setpoint_code,
  input  logic               reduce_req,
  input  logic               hys_max,
  input  logic               sensor_open,
  output logic               gate_req,
  output logic [SAW_W-1:0]   saw_level
);
  // Named internal events, observed by the bound checker.
  logic             pos_evt;
  logic             neg_evt;
  logic             eval_tick;
  logic             cmp_q;
  logic             fire_now;
  logic             fire_hc;
  logic             pulse_start;
  logic             gate_active;
  logic [CNT_W-1:0] cnt_q;

  assign pos_evt = zc_evt && zc_pos;
  assign neg_evt = zc_evt && !zc_pos;

  bf_period_counter #(.CNT_W(CNT_W), .SAW_W(SAW_W), .DEC_PER(DEC_PER)) u_cnt (
    .clk(clk), .rst(rst), .pos_evt(pos_evt),
    .cnt_q(cnt_q), .saw(saw_level), .eval_tick(eval_tick)
  );

  bf_decider #(.SENSE_W(SENSE_W), .SAW_W(SAW_W), .RED_CODES(RED_CODES),
               .HYS_MIN(HYS_MIN), .HYS_MAX(HYS_MAX)) u_dec (
    .clk(clk), .rst(rst), .eval_tick(eval_tick), .sense(sense_code),
    .setpoint(setpoint_code), .saw(saw_level), .reduce_req(reduce_req),
    .hys_max(hys_max), .cmp_q(cmp_q), .fire_now(fire_now)
  );

  bf_pulse_gen #(.PULSE_HALF(PULSE_HALF)) u_pg (
    .clk(clk), .rst(rst), .pos_evt(pos_evt), .neg_evt(neg_evt),
    .fire_now(fire_now), .sensor_open(sensor_open), .fire_hc(fire_hc),
    .pulse_start(pulse_start), .gate_active(gate_active), .gate_req(gate_req)
  );
endmodule

// File: rtl/bf_checker.sv
module bf_checker #(
  parameter int CNT_W = 11,
  parameter int PW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pos_evt,
  input logic             neg_evt,
  input logic             sensor_open,
  input logic [CNT_W-1:0] cnt_q,
  input logic             eval_tick,
  input logic             cmp_q,
  input logic             pulse_start,
  input logic             gate_active
);
  logic [15:0] run_q;
  logic        armed_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else run_q <= gate_active ? run_q + 16'd1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || sensor_open)         armed_q <= 1'b0;
    else if (pulse_start && pos_evt) armed_q <= 1'b1;
    else if (neg_evt)               armed_q <= 1'b0;
  end

  assert_saw_step_R2: assert property (@(posedge clk) disable iff (rst)
    pos_evt |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_saw_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !pos_evt |=> $stable(cnt_q));

  assert_eval_gap_R5: assert property (@(posedge clk) disable iff (rst)
    !eval_tick |=> $stable(cmp_q));

  assert_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (pulse_start && neg_evt) |-> armed_q);

  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
    gate_active |-> run_q < 16'(PW));

  assert_failsafe_R8: assert property (@(posedge clk) disable iff (rst)
    sensor_open |=> !gate_active);
endmodule

bind burst_fire_ctrl bf_checker #(.CNT_W(CNT_W), .PW(2 * PULSE_HALF)) u_chk (
  .clk(clk), .rst(rst), .pos_evt(pos_evt), .neg_evt(neg_evt),
  .sensor_open(sensor_open), .cnt_q(cnt_q), .eval_tick(eval_tick),
  .cmp_q(cmp_q), .pulse_start(pulse_start), .gate_active(gate_active)
);

// File: tb/sim_burst_fire_ctrl.sv
module sim_burst_fire_ctrl;
  localparam int SENSE_W = 8, CNT_W = 6, SAW_W = 4, DEC_PER = 3, PULSE_HALF = 2;
  localparam int RED = 20, HMIN = 1, HMAX = 12, SP = 100, HALF_LEN = 12;

  logic clk = 1'b0, rst = 1'b1, zc_evt = 1'b0, zc_pos = 1'b0;
  logic [SENSE_W-1:0] sense_code = '0, setpoint_code = SP[SENSE_W-1:0];
  logic reduce_req = 1'b0, hys_max = 1'b0, sensor_open = 1'b0;
  logic gate_req;
  logic [SAW_W-1:0] saw_level;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  // bench-side model state
  int m_cnt = 0, m_dec = 0;
  bit m_on = 1'b0, m_latch = 1'b0;

  always #2 clk = ~clk;

  burst_fire_ctrl #(.SENSE_W(SENSE_W), .CNT_W(CNT_W), .SAW_W(SAW_W), .DEC_PER(DEC_PER),
                    .PULSE_HALF(PULSE_HALF), .RED_CODES(RED), .HYS_MIN(HMIN),
                    .HYS_MAX(HMAX)) u0 (
    .clk(clk), .rst(rst), .zc_evt(zc_evt), .zc_pos(zc_pos), .sense_code(sense_code),
    .setpoint_code(setpoint_code), .reduce_req(reduce_req), .hys_max(hys_max),
    .sensor_open(sensor_open), .gate_req(gate_req), .saw_level(saw_level));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Model of one crossing; returns whether a pulse is expected.
  function automatic bit model_step(input bit pos, output string tag);
    bit fire;
    int step, lvl, thr;
    tag = pos ? "R6" : "R6";
    if (pos) begin
      step = 1 << (CNT_W - SAW_W);
      lvl  = m_cnt / step;
      if (m_dec == 0) begin
        thr  = SP + lvl - (reduce_req ? RED : 0);
        if (m_on) thr += (hys_max ? HMAX : HMIN);
        m_on = int'(sense_code) < thr;
        tag  = m_on && hys_max ? "R4" : "R3";
      end else tag = "R5";
      m_dec   = (m_dec + 1) % DEC_PER;
      m_cnt   = (m_cnt + 1) % (1 << CNT_W);
      fire    = m_on && !sensor_open;
      m_latch = fire;
    end else begin
      fire    = m_latch && !sensor_open;
      m_latch = 1'b0;
    end
    return fire;
  endfunction

  task automatic half_cycle(input bit pos);
    bit exp_p;
    string tag;
    int highs;
    @(negedge clk);
    zc_evt = 1'b1; zc_pos = pos;
    exp_p = model_step(pos, tag);
    @(negedge clk);
    zc_evt = 1'b0;
    check(tag, int'(gate_req), int'(exp_p));
    if (pos) check("R2 saw", int'(saw_level), m_cnt >> (CNT_W - SAW_W));
    highs = int'(gate_req);
    for (int i = 1; i < HALF_LEN; i++) begin
      @(negedge clk);
      highs += int'(gate_req);
    end
    check("R7 width", highs, exp_p ? 2 * PULSE_HALF : 0);
  endtask

  initial begin
    #700000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 gate", int'(gate_req), 0);
    check("R1 saw", int'(saw_level), 0);
    // Sweep: reduction x hysteresis x sensor level across full ramps.
    for (int r = 0; r < 2; r++) begin
      for (int h = 0; h < 2; h++) begin
        reduce_req = r[0]; hys_max = h[0];
        for (int s = 70; s <= 126; s += 7) begin
          sense_code = s[SENSE_W-1:0];
          for (int p = 0; p < (1 << CNT_W); p++) begin
            half_cycle(1'b1);
            half_cycle(1'b0);
          end
        end
      end
    end
    // R5: decision held between evaluations.
    reduce_req = 1'b0; hys_max = 1'b0; sense_code = 8'd0;
    while (m_dec != 1 || !m_on) begin half_cycle(1'b1); half_cycle(1'b0); end
    sense_code = 8'd250;
    half_cycle(1'b1); half_cycle(1'b0);
    check("R5 held", int'(m_on), 1);
    sense_code = 8'd0;
    while (m_dec != 0) begin half_cycle(1'b1); half_cycle(1'b0); end
    // R8: failsafe raised in mid-pulse cancels the pair.
    begin
      bit e;
      string t;
      @(negedge clk);
      zc_evt = 1'b1; zc_pos = 1'b1;
      e = model_step(1'b1, t);
      @(negedge clk);
      zc_evt = 1'b0;
      check("R6 first pulse", int'(gate_req), int'(e));
      @(negedge clk);
      sensor_open = 1'b1;
      #1;
      check("R8 immediate", int'(gate_req), 0);
      m_latch = 1'b0;
      repeat (HALF_LEN) @(negedge clk);
      half_cycle(1'b0);
      half_cycle(1'b1);
      half_cycle(1'b0);
      sensor_open = 1'b0;
      half_cycle(1'b1);
      check("R8 recovers", int'(m_latch), 1);
      half_cycle(1'b0);
    end
    // R6: stray negative crossings without a latched decision.
    half_cycle(1'b0);
    half_cycle(1'b0);
    // R1: reset clears counter and outputs.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_dec = 0; m_on = 1'b0; m_latch = 1'b0;
    @(negedge clk);
    check("R1 saw after reset", int'(saw_level), 0);
    check("R1 gate after reset", int'(gate_req), 0);
    half_cycle(1'b1);
    half_cycle(1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule